// File: doc/BRIEF.md
# Three-Channel Multi-Mode Timer

This block holds three independent timer channels behind one small register interface. Each channel owns one pin, split at the block edge into an input, an output and an output enable. It runs in one of three modes:
- **Pulse generation** drives a repeating pulse with a programmed period and high time.
- **Pulse measurement** samples the pin and records the length and the repeat interval of an incoming pulse.
- **Event watchdog** restarts a window on every selected pin edge. It flags expiry when no edge arrives within the window.

A channel raises a one-cycle interrupt and a sticky status flag on each of its events.

One shared word holds a run bit for every channel and the sticky status flags, which are cleared by writing ones. Each channel also has a 6-bit mode word and 32-bit count, period and width words. Software fills the period and width words for pulse generation. Hardware fills them in measurement mode. Clearing a run bit freezes that channel's counter and releases its pin. Reads are registered and return, one cycle later, the state seen at the address presented.

Top module: `gp_timer_unit`

## Requirements
- R1: After reset every run bit, status flag, mode word, count, period and width reads 0, all pin enables and interrupts are low, and read data is 0.
- R2: Address = {channel index[1:0], word select[1:0]}, with select 0 = mode word, 1 = count, 2 = period, 3 = width; address 0xC is the shared word, run bits in [2:0] (read/write) and status in [10:8]; read data shows the addressed word one cycle after the address.
- R3: Mode word bits [1:0] = 01 selects pulse generation: while running, the count steps 1,2,...,period and, when count ≥ period, returns to 1 and produces an event.
- R4: In pulse generation the pin enable is high (one cycle after run and mode are set) and the pin is at its active level while count ≤ width; mode bit 2 = 1 makes the active level low.
- R5: Mode 10 measures pulses: input passes a 2-flop synchronizer; a leading edge (rising if mode bit 4 = 0, falling if 1) restarts the count at 1 and latches the previous count into period; a trailing edge latches the count into width.
- R6: In measurement, the first leading edge after entering the mode only arms the channel; afterwards an event occurs on leading edges when mode bit 5 = 0 and on trailing edges when bit 5 = 1.
- R7: Mode 11 is the watchdog: each selected edge (bit 4 as in R5) clears the count; without edges an event occurs every period cycles and the count restarts from 0.
- R8: A status flag is set by its channel's event and kept until a write to 0xC with a one in its bit; an event in the same cycle as the clear leaves it set.
- R9: The interrupt is a one-cycle pulse following each event, only when mode bit 3 = 1; the status flag is set regardless.
- R10: With its run bit clear a channel keeps its count frozen, drops its pin enable on the next cycle and keeps its period and width words.
- R11: Writes to a count address are ignored; mode 00 leaves the channel idle with a held count and pin enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tmr_pin_i | input | 3 | Pin input level per channel |
| tmr_pin_o | output | 3 | Pin output level per channel |
| tmr_pin_oe | output | 3 | Pin output enable per channel |
| tmr_irq | output | 3 | Interrupt pulse per channel |

## Verification
A channel event that sets a status flag can land in the same cycle as a software write clearing that same flag. The bench provokes this collision by holding a write of ones to the status field over several consecutive cycles while a pulse-generation channel with a five-cycle period is wrapping. During that window, each cycle's status read must equal the interrupt seen one cycle earlier. The flag is therefore set only where an event coincided with a clear, and cleared everywhere else. A behavioural reference model also compares every pin, interrupt and read-data value on every clock.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_WAVE = 2'b01,
    MODE_CAP  = 2'b10,
    MODE_WDOG = 2'b11
  } gpt_mode_e;

  typedef struct packed {
    logic      irq_on_width;
    logic      lead_fall;
    logic      irq_en;
    logic      active_low;
    gpt_mode_e mode;
  } gpt_cfg_t;

  localparam int CFG_W    = 6;
  localparam int STAT_LSB = 8;

  localparam logic [1:0] SEL_CFG = 2'd0;
  localparam logic [1:0] SEL_CNT = 2'd1;
  localparam logic [1:0] SEL_PER = 2'd2;
  localparam logic [1:0] SEL_WID = 2'd3;

endpackage

// File: rtl/gpt_edge_detect.sv
module gpt_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-1:0], din};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cfg_we,
  input  logic             per_we,
  input  logic             wid_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             pin_oe,
  output logic             irq_o,
  output logic             evt_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] wid_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  gpt_cfg_t         cfg_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, wid_q, wid_d;
  logic             arm_q, arm_d;
  logic             evt, pin_d, oe_d;
  logic             pin_q, oe_q, irq_q;
  logic             rise, fall, lead, trail;

  gpt_edge_detect #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign lead  = cfg_q.lead_fall ? fall : rise;
  assign trail = cfg_q.lead_fall ? rise : fall;

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_we ? wdata : per_q;
    wid_d = wid_we ? wdata : wid_q;
    arm_d = arm_q;
    evt   = 1'b0;
    pin_d = 1'b0;
    oe_d  = 1'b0;
    if (en) begin
      case (cfg_q.mode)
        MODE_WAVE: begin
          if (cnt_q >= per_q) begin
            cnt_d = ONE;
            evt   = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
          pin_d = (cnt_d <= wid_q) ^ cfg_q.active_low;
          oe_d  = 1'b1;
        end
        MODE_CAP: begin
          if (lead) begin
            if (arm_q) begin
              per_d = cnt_q;
              evt   = !cfg_q.irq_on_width;
            end
            arm_d = 1'b1;
            cnt_d = ONE;
          end else if (arm_q) begin
            cnt_d = cnt_q + ONE;
            if (trail) begin
              wid_d = cnt_q;
              evt   = cfg_q.irq_on_width;
            end
          end
        end
        MODE_WDOG: begin
          if (lead) begin
            cnt_d = '0;
          end else if (cnt_q + ONE >= per_q) begin
            cnt_d = '0;
            evt   = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: ;
      endcase
    end
    if (!(en && cfg_q.mode == MODE_CAP)) arm_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cnt_q <= '0;
      per_q <= '0;
      wid_q <= '0;
      arm_q <= 1'b0;
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= gpt_cfg_t'(wdata[CFG_W-1:0]);
      cnt_q <= cnt_d;
      per_q <= per_d;
      wid_q <= wid_d;
      arm_q <= arm_d;
      pin_q <= pin_d;
      oe_q  <= oe_d;
      irq_q <= evt & cfg_q.irq_en;
    end
  end

  assign pin_o  = pin_q;
  assign pin_oe = oe_q;
  assign irq_o  = irq_q;
  assign evt_o  = evt;
  assign cfg_o  = cfg_q;
  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign wid_o  = wid_q;

  // R4: the pin is driven only after a cycle of running in pulse generation
  p_oe_wave_r4: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> ($past(en) && $past(cfg_q.mode) == MODE_WAVE));

  // R3: a pulse-generation event restarts the count at 1
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (en && cfg_q.mode == MODE_WAVE && evt) |=> (cnt_q == ONE));

  // R10: a stopped channel keeps its count
  p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q));

  // R9: an interrupt follows an event with the interrupt enabled
  p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(evt) && $past(cfg_q.irq_en)));

  // R6: measurement events need an armed channel
  p_cap_armed_r6: assert property (@(posedge clk) disable iff (rst)
    (evt && cfg_q.mode == MODE_CAP) |-> arm_q);

endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int N_TMR  = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [N_TMR-1:0]            wr_run,
  input  logic [N_TMR-1:0]            wr_clr,
  input  logic [N_TMR-1:0]            evt,
  input  logic [N_TMR-1:0][CFG_W-1:0] cfg_all,
  input  logic [N_TMR-1:0][CNT_W-1:0] cnt_all,
  input  logic [N_TMR-1:0][CNT_W-1:0] per_all,
  input  logic [N_TMR-1:0][CNT_W-1:0] wid_all,
  output logic [N_TMR-1:0]            en_o,
  output logic [N_TMR-1:0]            cfg_we,
  output logic [N_TMR-1:0]            per_we,
  output logic [N_TMR-1:0]            wid_we,
  output logic [CNT_W-1:0]            rdata
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] SHARED_IDX = IDX_W'(N_TMR);

  logic [IDX_W-1:0] idx;
  logic [1:0]       sel;
  logic             hit_shared;
  logic [N_TMR-1:0] en_q, st_q, clr_vec;
  logic [CNT_W-1:0] rd_mux, shared_word;

  assign idx        = addr[ADDR_W-1:2];
  assign sel        = addr[1:0];
  assign hit_shared = we && (idx == SHARED_IDX) && (sel == SEL_CFG);
  assign clr_vec    = hit_shared ? wr_clr : '0;

  for (genvar g = 0; g < N_TMR; g++) begin : g_dec
    assign cfg_we[g] = we && (idx == IDX_W'(g)) && (sel == SEL_CFG);
    assign per_we[g] = we && (idx == IDX_W'(g)) && (sel == SEL_PER);
    assign wid_we[g] = we && (idx == IDX_W'(g)) && (sel == SEL_WID);
  end

  always_comb begin
    shared_word = '0;
    shared_word[N_TMR-1:0]          = en_q;
    shared_word[STAT_LSB +: N_TMR]  = st_q;
  end

  always_comb begin
    rd_mux = '0;
    if (idx == SHARED_IDX) begin
      if (sel == SEL_CFG) rd_mux = shared_word;
    end else begin
      for (int g = 0; g < N_TMR; g++) begin
        if (idx == IDX_W'(g)) begin
          case (sel)
            SEL_CFG: rd_mux = CNT_W'(cfg_all[g]);
            SEL_CNT: rd_mux = cnt_all[g];
            SEL_PER: rd_mux = per_all[g];
            default: rd_mux = wid_all[g];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      st_q  <= '0;
      rdata <= '0;
    end else begin
      if (hit_shared) en_q <= wr_run;
      st_q  <= (st_q & ~clr_vec) | evt;
      rdata <= rd_mux;
    end
  end

  assign en_o = en_q;

  // R8: flags not being cleared stay set
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_q & $past(st_q & ~clr_vec)) == $past(st_q & ~clr_vec)));

  // R8: every event leaves its flag set, even under a same-cycle clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((st_q & $past(evt)) == $past(evt)));

  // R2: a shared-word write loads the run bits
  p_run_write_r2: assert property (@(posedge clk) disable iff (rst)
    hit_shared |=> (en_q == $past(wr_run)));

endmodule

// File: rtl/gp_timer_unit.sv
module gp_timer_unit
  import gpt_pkg::*;
#(
  parameter int N_TMR       = 3,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(N_TMR + 1) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [N_TMR-1:0]  tmr_pin_i,
  output logic [N_TMR-1:0]  tmr_pin_o,
  output logic [N_TMR-1:0]  tmr_pin_oe,
  output logic [N_TMR-1:0]  tmr_irq
);

  logic [N_TMR-1:0]            en_vec, evt_vec, cfg_we, per_we, wid_we;
  logic [N_TMR-1:0][CFG_W-1:0] cfg_all;
  logic [N_TMR-1:0][CNT_W-1:0] cnt_all, per_all, wid_all;

  gpt_regs #(
    .N_TMR  (N_TMR),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .addr    (bus_addr),
    .wr_run  (bus_wdata[N_TMR-1:0]),
    .wr_clr  (bus_wdata[STAT_LSB +: N_TMR]),
    .evt     (evt_vec),
    .cfg_all (cfg_all),
    .cnt_all (cnt_all),
    .per_all (per_all),
    .wid_all (wid_all),
    .en_o    (en_vec),
    .cfg_we  (cfg_we),
    .per_we  (per_we),
    .wid_we  (wid_we),
    .rdata   (bus_rdata)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_ch
    gpt_channel #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_ch (
      .clk    (clk),
      .rst    (rst),
      .en     (en_vec[g]),
      .cfg_we (cfg_we[g]),
      .per_we (per_we[g]),
      .wid_we (wid_we[g]),
      .wdata  (bus_wdata),
      .pin_i  (tmr_pin_i[g]),
      .pin_o  (tmr_pin_o[g]),
      .pin_oe (tmr_pin_oe[g]),
      .irq_o  (tmr_irq[g]),
      .evt_o  (evt_vec[g]),
      .cfg_o  (cfg_all[g]),
      .cnt_o  (cnt_all[g]),
      .per_o  (per_all[g]),
      .wid_o  (wid_all[g])
    );
  end

endmodule

// File: tb/sim_gp_timer_unit.sv
`timescale 1ns/1ps
module sim_gp_timer_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  tmr_pin_i = '0;
  logic [2:0]  tmr_pin_o, tmr_pin_oe, tmr_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int irq_seen = 0;
  logic live = 1'b0;

  always #4 clk = ~clk;

  gp_timer_unit u0 (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tmr_pin_i  (tmr_pin_i),
    .tmr_pin_o  (tmr_pin_o),
    .tmr_pin_oe (tmr_pin_oe),
    .tmr_irq    (tmr_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt [3];
  logic [31:0] m_per [3];
  logic [31:0] m_wid [3];
  logic [5:0]  m_cfg [3];
  logic [2:0]  m_hist [3];
  logic        m_arm [3];
  logic [2:0]  m_en, m_st, m_pin, m_oe, m_irq;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    live <= !rst;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 0; m_per[i] = 0; m_wid[i] = 0; m_cfg[i] = 0;
        m_hist[i] = 0; m_arm[i] = 0;
      end
      m_en = 0; m_st = 0; m_pin = 0; m_oe = 0; m_irq = 0; m_rd = 0;
    end else begin
      logic [31:0] rd_next;
      logic [2:0]  st_next, en_next;
      int ch, sl;
      ch = bus_addr / 4;
      sl = bus_addr % 4;
      rd_next = 0;
      if (ch == 3) begin
        if (sl == 0) rd_next = {21'd0, m_st, 5'd0, m_en};
      end else begin
        if (sl == 0) rd_next = {26'd0, m_cfg[ch]};
        else if (sl == 1) rd_next = m_cnt[ch];
        else if (sl == 2) rd_next = m_per[ch];
        else rd_next = m_wid[ch];
      end
      st_next = m_st;
      if (bus_we && bus_addr == 4'hC) st_next = m_st & ~bus_wdata[10:8];
      en_next = (bus_we && bus_addr == 4'hC) ? bus_wdata[2:0] : m_en;
      for (int i = 0; i < 3; i++) begin
        logic [31:0] c, p, w;
        logic ev, up, dn, ld, tr, run;
        int md;
        md  = m_cfg[i][1:0];
        up  = m_hist[i][1] && !m_hist[i][2];
        dn  = !m_hist[i][1] && m_hist[i][2];
        ld  = m_cfg[i][4] ? dn : up;
        tr  = m_cfg[i][4] ? up : dn;
        run = m_en[i];
        c = m_cnt[i];
        p = (bus_we && bus_addr == 4*i + 2) ? bus_wdata : m_per[i];
        w = (bus_we && bus_addr == 4*i + 3) ? bus_wdata : m_wid[i];
        ev = 0;
        m_pin[i] = 0;
        m_oe[i]  = 0;
        if (run && md == 1) begin
          if (m_cnt[i] >= m_per[i]) begin c = 1; ev = 1; end
          else c = m_cnt[i] + 1;
          m_pin[i] = (c <= m_wid[i]) ^ m_cfg[i][2];
          m_oe[i]  = 1;
        end else if (run && md == 2) begin
          if (ld) begin
            if (m_arm[i]) begin p = m_cnt[i]; ev = !m_cfg[i][5]; end
            c = 1;
            m_arm[i] = 1;
          end else if (m_arm[i]) begin
            c = m_cnt[i] + 1;
            if (tr) begin w = m_cnt[i]; ev = m_cfg[i][5]; end
          end
        end else if (run && md == 3) begin
          if (ld) c = 0;
          else if (m_cnt[i] + 1 >= m_per[i]) begin c = 0; ev = 1; end
          else c = m_cnt[i] + 1;
        end
        if (!(run && md == 2)) m_arm[i] = 0;
        m_irq[i] = ev && m_cfg[i][3];
        if (ev) st_next[i] = 1;
        if (bus_we && bus_addr == 4*i) m_cfg[i] = bus_wdata[5:0];
        m_cnt[i] = c; m_per[i] = p; m_wid[i] = w;
        m_hist[i] = {m_hist[i][1:0], tmr_pin_i[i]};
      end
      m_st = st_next;
      m_en = en_next;
      m_rd = rd_next;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check("R4 pin level vs model", {29'd0, tmr_pin_o}, {29'd0, m_pin});
      check("R4 pin enable vs model", {29'd0, tmr_pin_oe}, {29'd0, m_oe});
      check("R9 irq vs model", {29'd0, tmr_irq}, {29'd0, m_irq});
      check("R2 read data vs model", bus_rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic drive(input int ch, input logic lvl, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tmr_irq[ch]) irq_seen++;
      tmr_pin_i[ch] = lvl;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int hi, irqs, prev_irq, hits;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(4'hC, v);  check("R1 shared word", v, 32'h0);
    rd(4'h0, v);  check("R1 mode word", v, 32'h0);
    rd(4'h2, v);  check("R1 period", v, 32'h0);
    check("R1 pin enable", {29'd0, tmr_pin_oe}, 32'h0);
    check("R1 irq", {29'd0, tmr_irq}, 32'h0);

    // R3 R4: pulse generation, period 5, width 2, irq on
    wr(4'h2, 32'd5);
    wr(4'h3, 32'd2);
    wr(4'h0, 32'h09);
    wr(4'hC, 32'h1);
    repeat (10) @(negedge clk);
    hi = 0; irqs = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      hi += tmr_pin_o[0];
      irqs += tmr_irq[0];
    end
    check("R4 active cycles per 10", hi, 4);
    check("R3 wraps per 10", irqs, 2);
    check("R4 pin driven", {31'd0, tmr_pin_oe[0]}, 32'd1);
    rd(4'h1, v);
    check("R3 count within 1..period", {31'd0, (v >= 1 && v <= 5)}, 32'd1);

    wr(4'h0, 32'h0D);
    repeat (10) @(negedge clk);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      hi += tmr_pin_o[0];
    end
    check("R4 inverted polarity high cycles", hi, 6);

    // R8: clear held across wraps; set must win in a colliding cycle
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'hC; bus_wdata = 32'h101;
    prev_irq = 0; hits = 0;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      if (j == 1) check("R8 sticky before clear", {31'd0, bus_rdata[8]}, 32'd1);
      else begin
        check("R8 flag vs same-cycle event", {31'd0, bus_rdata[8]}, prev_irq);
        hits += prev_irq;
      end
      prev_irq = tmr_irq[0];
    end
    bus_we = 1'b0;
    check("R8 collision provoked", {31'd0, (hits > 0)}, 32'd1);

    // R10: stop channel 0
    wr(4'hC, 32'h0);
    repeat (2) @(negedge clk);
    check("R10 pin released", {31'd0, tmr_pin_oe[0]}, 32'd0);
    rd(4'h1, v);
    repeat (5) @(negedge clk);
    rd(4'h1, v2);
    check("R10 count frozen", v2, v);
    rd(4'h2, v2);  check("R10 period kept", v2, 32'd5);
    rd(4'h3, v2);  check("R10 width kept", v2, 32'd2);

    // R11: count is read-only
    wr(4'h1, 32'h1234);
    rd(4'h1, v2);
    check("R11 count write ignored", v2, v);

    // R5 R6: measurement on channel 1, rising lead, irq on lead
    wr(4'h4, 32'h0A);
    wr(4'hC, 32'h2);
    irq_seen = 0;
    drive(1, 1'b0, 4);
    drive(1, 1'b1, 7);
    drive(1, 1'b0, 5);
    drive(1, 1'b1, 7);
    drive(1, 1'b0, 5);
    drive(1, 1'b1, 10);
    check("R6 first lead only arms", irq_seen, 2);
    rd(4'h7, v);  check("R5 measured width", v, 32'd7);
    rd(4'h6, v);  check("R5 measured period", v, 32'd12);

    // R5 R6: falling lead, irq on width edge
    wr(4'h4, 32'h3A);
    irq_seen = 0;
    drive(1, 1'b0, 3);
    drive(1, 1'b1, 6);
    drive(1, 1'b0, 3);
    drive(1, 1'b1, 10);
    check("R6 irq on trailing edges", irq_seen, 2);
    rd(4'h7, v);  check("R5 low-phase width", v, 32'd3);
    rd(4'h6, v);  check("R5 falling-edge period", v, 32'd9);

    // R7: watchdog on channel 2, window 8
    wr(4'hA, 32'd8);
    wr(4'h8, 32'h0B);
    wr(4'hC, 32'h4);
    irq_seen = 0;
    for (int k = 0; k < 5; k++) begin
      drive(2, 1'b1, 3);
      drive(2, 1'b0, 3);
    end
    check("R7 no expiry with edges", irq_seen, 0);
    drive(2, 1'b0, 10);
    irq_seen = 0;
    drive(2, 1'b0, 24);
    check("R7 expiries in 24 quiet cycles", irq_seen, 3);
    rd(4'hC, v);
    check("R7 expiry status", {31'd0, v[10]}, 32'd1);

    // R11: idle mode holds the count
    wr(4'h8, 32'h00);
    rd(4'h9, v);
    repeat (6) @(negedge clk);
    rd(4'h9, v2);
    check("R11 idle count held", v2, v);
    check("R11 idle pin enable", {31'd0, tmr_pin_oe[2]}, 32'd0);

    // R9: interrupt masked but status still set
    wr(4'h0, 32'h01);
    wr(4'hC, 32'h701);
    irqs = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      irqs += tmr_irq[0];
    end
    check("R9 masked irq", irqs, 0);
    rd(4'hC, v);
    check("R9 status without irq", {31'd0, v[8]}, 32'd1);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule